// File: doc/BRIEF.md
# Banked Memory Map Controller

This block decodes every access from an 8-bit CPU with a 16-bit address bus and steers it to a boot ROM, main RAM, a separate attribute RAM that holds the ninth bit of each display cell, or a group of peripheral chip selects. Two bits of state set the map. The overlay flag places the boot ROM and the peripheral window over the lowest 16 KB. The attribute flag redirects the top 4 KB to the attribute RAM. Software changes both flags with I/O writes. Only the low two port-address bits pick the action, and the data bus plays no part.

The peripheral window decodes loosely. Each select compares only two bits of the 12-bit window offset, so one access can assert several selects at once. Main RAM, ROM and attribute RAM are external arrays. The block drives their strobes and addresses and muxes their read data back onto the CPU read bus. A small display option register inside the window holds two mode flags, and the block drives both flags out as ports.

Top module: `bank_map_ctrl`

## Requirements
- R1: After a synchronous active-low reset the overlay is on, the attribute flag is clear, and both display flags are 0.
- R2: An I/O write (`io_wr` high at a clock edge) performs an action chosen only by `cpu_addr[1:0]`, whatever the rest of the port address and whatever `cpu_wdata` holds. The codes are: 0 = overlay on, 1 = overlay off, 2 = attribute flag set, 3 = attribute flag clear.
- R3: With the overlay on, reads of 0000-1FFF assert `rom_cs` with `rom_addr = cpu_addr[11:0]`. 1000-1FFF therefore mirrors the 4 KB ROM, and `cpu_rdata` returns `rom_rdata`.
- R4: With the overlay on, memory writes to 0000-1FFF are dropped: `rom_cs`, `ram_cs` and `ram_we` all stay low.
- R5: With the overlay on, 2000-3FFF is the peripheral window and 3000-3FFF mirrors 2000-2FFF. With offset = `cpu_addr[11:0]` the selects are: floppy when (offset & 0x900) == 0x100, display register when (offset & 0xC00) == 0x400, bus-interface when (offset & 0x900) == 0x900, serial when (offset & 0xA00) == 0xA00, video when (offset & 0xC00) == 0xC00. Several may assert together, and `periph_reg = cpu_addr[1:0]`.
- R6: A window read returns `periph_rdata` when any of the floppy, bus-interface, serial or video selects is asserted, and 0xFF otherwise.
- R7: With the overlay off, all reads and writes to 0000-3FFF go to main RAM at the CPU address.
- R8: Addresses 4000-EFFF always go to main RAM, whatever the state.
- R9: With the attribute flag set, F000-FFFF goes to the attribute RAM at `attr_addr = cpu_addr[11:0]`. Write data has bits [6:0] forced to 1.
- R10: With the attribute flag clear, F000-FFFF goes to main RAM.
- R11: A memory write that hits the display register latches `cpu_wdata[0]` into `disp_hires` and `cpu_wdata[1]` into `disp_shift`.
- R12: Memory decode is combinational from the current state. A state change from an I/O write is first visible after the clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address (memory or I/O) |
| cpu_wdata | input | 8 | CPU write data |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| cpu_rdata | output | 8 | Read data to the CPU |
| rom_cs | output | 1 | Boot ROM read select |
| rom_addr | output | 12 | Boot ROM address |
| rom_rdata | input | 8 | Boot ROM data |
| ram_cs | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write enable |
| ram_addr | output | 16 | Main RAM address |
| ram_wdata | output | 8 | Main RAM write data |
| ram_rdata | input | 8 | Main RAM data |
| attr_cs | output | 1 | Attribute RAM select |
| attr_we | output | 1 | Attribute RAM write enable |
| attr_addr | output | 12 | Attribute RAM address |
| attr_wdata | output | 8 | Attribute RAM write data, low 7 bits forced high |
| attr_rdata | input | 8 | Attribute RAM data |
| floppy_cs | output | 1 | Floppy controller select |
| busif_cs | output | 1 | Bus-interface PIA select |
| serial_cs | output | 1 | Serial port select |
| video_cs | output | 1 | Video PIA select |
| periph_reg | output | 2 | Peripheral register index |
| periph_rd | output | 1 | Peripheral read strobe |
| periph_wr | output | 1 | Peripheral write strobe |
| periph_rdata | input | 8 | Shared peripheral read data |
| overlay_on | output | 1 | Overlay flag |
| attr_on | output | 1 | Attribute plane flag |
| disp_hires | output | 1 | Display resolution flag |
| disp_shift | output | 1 | Display left-shift flag |

## Verification
The bench probes window offsets where the two-bit masks overlap, such as 0xF00 and 0x500, and offsets that match nothing, such as 0x000 and 0x800. A full four-bit decode would drop the extra selects there, and a missing default would return stale bus data where 0xFF is due. It makes I/O writes with high port bits set and with opposite data values. A decoder that used more than `cpu_addr[1:0]` or looked at the data would take the wrong bank action. It writes the attribute plane with all-zero data and expects 0x7F. It also reads 1000-1FFF expecting ROM at the folded address, and writes under the overlay expecting nothing to reach RAM.

// File: rtl/bank_map_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the banked memory map controller.
// Assumes a byte-wide CPU and 4 KB pages.
package bank_map_pkg;
    // Destination of a memory access
    typedef enum logic [1:0] {
        TGT_RAM  = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_ATTR = 2'd2,
        TGT_WIN  = 2'd3
    } target_e;

    // Action coded in the low port-address bits of an I/O write
    typedef enum logic [1:0] {
        ACT_OVL_ON   = 2'd0,
        ACT_OVL_OFF  = 2'd1,
        ACT_ATTR_SET = 2'd2,
        ACT_ATTR_CLR = 2'd3
    } io_act_e;
endpackage

// File: rtl/bank_state_reg.sv
`timescale 1ns/1ps
// Module: bank_state_reg
// Holds the overlay and attribute-plane flags. An I/O write that is high at
// a clock edge applies the action coded in the two low port-address bits.
// Assumes io_wr is qualified by the CPU bus cycle. Holding it high repeats
// the same action, which has no further effect.
module bank_state_reg
    import bank_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [1:0] io_code,
    output logic       overlay_o,
    output logic       attr_o
);
    logic overlay_q;
    logic attr_q;

    // Apply the I/O action; reset restores the boot overlay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overlay_q <= 1'b1;
            attr_q    <= 1'b0;
        end else if (io_wr) begin
            unique case (io_act_e'(io_code))
                ACT_OVL_ON:   overlay_q <= 1'b1;
                ACT_OVL_OFF:  overlay_q <= 1'b0;
                ACT_ATTR_SET: attr_q    <= 1'b1;
                ACT_ATTR_CLR: attr_q    <= 1'b0;
                default:      ;
            endcase
        end
    end

    assign overlay_o = overlay_q;
    assign attr_o    = attr_q;

    // R2
    io_off_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_code == 2'd1) |=> !overlay_o);

    // R2
    io_attr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_code == 2'd2) |=> (attr_o && $stable(overlay_o)));

    // R12
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(overlay_o) && $stable(attr_o)));
endmodule

// File: rtl/win_decode.sv
`timescale 1ns/1ps
// Module: win_decode
// Loose peripheral decode inside the I/O window. Each select compares two
// offset bits only, so several can fire on one access. Also holds the
// display option register (two flags written through the window).
// Assumes win_acc is high only for window accesses with the overlay on.
module win_decode #(
    parameter int OFS_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_acc,
    input  logic              win_wr,
    input  logic [OFS_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic              floppy_sel,
    output logic              busif_sel,
    output logic              serial_sel,
    output logic              video_sel,
    output logic              disp_sel,
    output logic              hires_o,
    output logic              shift_o
);
    localparam int NSEL = 5;
    // mask/match pairs, entry order: floppy, display, bus-if, serial, video
    localparam logic [NSEL*OFS_W-1:0] MASKS = {
        12'hC00, 12'hA00, 12'h900, 12'hC00, 12'h900};
    localparam logic [NSEL*OFS_W-1:0] MATCH = {
        12'hC00, 12'hA00, 12'h900, 12'h400, 12'h100};

    logic [NSEL-1:0] hit;
    logic hires_q;
    logic shift_q;

    // One masked comparator per peripheral
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign hit[g] = win_acc &&
            ((offset & MASKS[g*OFS_W +: OFS_W]) == MATCH[g*OFS_W +: OFS_W]);
    end

    assign floppy_sel = hit[0];
    assign disp_sel   = hit[1];
    assign busif_sel  = hit[2];
    assign serial_sel = hit[3];
    assign video_sel  = hit[4];

    // Latch the display option flags on a register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hires_q <= 1'b0;
            shift_q <= 1'b0;
        end else if (win_wr && disp_sel) begin
            hires_q <= wdata[0];
            shift_q <= wdata[1];
        end
    end

    assign hires_o = hires_q;
    assign shift_o = shift_q;

    // R5
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> win_acc);

    // R11
    disp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && disp_sel) |=> (hires_o == $past(wdata[0]) &&
                                  shift_o == $past(wdata[1])));

    // R11
    disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_wr && disp_sel) |=> ($stable(hires_o) && $stable(shift_o)));
endmodule

// File: rtl/addr_steer.sv
`timescale 1ns/1ps
// Module: addr_steer
// Combinational map from the CPU address and bank flags to a target.
// The low four pages carry the overlay (ROM twice, then the window twice).
// The top page may be redirected to the attribute RAM. All else is RAM.
// Assumes mem_rd and mem_wr are never high together.
module addr_steer
    import bank_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              overlay,
    input  logic              attr_on,
    output target_e           target,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              attr_cs,
    output logic              attr_we,
    output logic              win_acc,
    output logic              win_wr
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic [PG_W-1:0] page;
    logic            acc;
    logic            in_low;
    logic            in_top;

    assign page   = addr[ADDR_W-1:PAGE_W];
    assign acc    = mem_rd | mem_wr;
    assign in_low = (page[PG_W-1:2] == '0);
    assign in_top = (page == '1);

    // Pick the destination of the current address
    always_comb begin
        if (overlay && in_low)
            target = page[1] ? TGT_WIN : TGT_ROM;
        else if (attr_on && in_top)
            target = TGT_ATTR;
        else
            target = TGT_RAM;
    end

    // Qualify strobes by destination
    always_comb begin
        rom_cs  = (target == TGT_ROM)  && mem_rd;
        ram_cs  = (target == TGT_RAM)  && acc;
        ram_we  = (target == TGT_RAM)  && mem_wr;
        attr_cs = (target == TGT_ATTR) && acc;
        attr_we = (target == TGT_ATTR) && mem_wr;
        win_acc = (target == TGT_WIN)  && acc;
        win_wr  = (target == TGT_WIN)  && mem_wr;
    end

    // R3
    one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, ram_cs, attr_cs, win_acc}));

    // R4
    rom_rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (mem_rd && !mem_wr && overlay));

    // R9
    attr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attr_cs |-> (attr_on && in_top));

    // R8
    mid_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_low && !in_top) |-> ram_cs);
endmodule

// File: rtl/bank_map_ctrl.sv
`timescale 1ns/1ps
// Module: bank_map_ctrl (top)
// Memory map controller for an 8-bit CPU: bank flags, address steering,
// loose peripheral decode and the CPU read-data mux.
// Assumes one CPU access per cycle and that the external arrays and
// peripherals return read data combinationally.
module bank_map_ctrl
    import bank_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 12,
    parameter int REG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              io_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rom_cs,
    output logic [PAGE_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              attr_cs,
    output logic              attr_we,
    output logic [PAGE_W-1:0] attr_addr,
    output logic [DATA_W-1:0] attr_wdata,
    input  logic [DATA_W-1:0] attr_rdata,
    output logic              floppy_cs,
    output logic              busif_cs,
    output logic              serial_cs,
    output logic              video_cs,
    output logic [REG_W-1:0]  periph_reg,
    output logic              periph_rd,
    output logic              periph_wr,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              overlay_on,
    output logic              attr_on,
    output logic              disp_hires,
    output logic              disp_shift
);
    localparam logic [DATA_W-1:0] IDLE_BYTE = '1;
    localparam logic [DATA_W-1:0] ATTR_FILL = {1'b0, {(DATA_W-1){1'b1}}};

    target_e target;
    logic    win_acc;
    logic    win_wr;
    logic    disp_sel;
    logic    ext_hit;

    bank_state_reg u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_code   (cpu_addr[1:0]),
        .overlay_o (overlay_on),
        .attr_o    (attr_on)
    );

    addr_steer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (cpu_addr),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .overlay (overlay_on),
        .attr_on (attr_on),
        .target  (target),
        .rom_cs  (rom_cs),
        .ram_cs  (ram_cs),
        .ram_we  (ram_we),
        .attr_cs (attr_cs),
        .attr_we (attr_we),
        .win_acc (win_acc),
        .win_wr  (win_wr)
    );

    win_decode #(.OFS_W(PAGE_W), .DATA_W(DATA_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_acc    (win_acc),
        .win_wr     (win_wr),
        .offset     (cpu_addr[PAGE_W-1:0]),
        .wdata      (cpu_wdata),
        .floppy_sel (floppy_cs),
        .busif_sel  (busif_cs),
        .serial_sel (serial_cs),
        .video_sel  (video_cs),
        .disp_sel   (disp_sel),
        .hires_o    (disp_hires),
        .shift_o    (disp_shift)
    );

    // Address and data fan-out to the arrays and peripherals
    assign rom_addr   = cpu_addr[PAGE_W-1:0];
    assign attr_addr  = cpu_addr[PAGE_W-1:0];
    assign ram_addr   = cpu_addr;
    assign ram_wdata  = cpu_wdata;
    assign attr_wdata = cpu_wdata | ATTR_FILL;
    assign periph_reg = cpu_addr[REG_W-1:0];
    assign periph_rd  = win_acc && mem_rd;
    assign periph_wr  = win_wr;
    assign ext_hit    = floppy_cs | busif_cs | serial_cs | video_cs;

    // Read-data mux back to the CPU
    always_comb begin
        cpu_rdata = IDLE_BYTE;
        if (mem_rd) begin
            unique case (target)
                TGT_ROM:  cpu_rdata = rom_rdata;
                TGT_RAM:  cpu_rdata = ram_rdata;
                TGT_ATTR: cpu_rdata = attr_rdata;
                TGT_WIN:  cpu_rdata = ext_hit ? periph_rdata : IDLE_BYTE;
                default:  cpu_rdata = IDLE_BYTE;
            endcase
        end
    end

    // R6
    win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rd && !ext_hit) |-> (cpu_rdata == IDLE_BYTE));

    // R9
    attr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attr_we |-> (attr_wdata[DATA_W-2:0] == ATTR_FILL[DATA_W-2:0]));

    // R7
    low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!overlay_on && (mem_rd || mem_wr) && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b00)
            |-> (ram_cs && !rom_cs && !periph_rd && !periph_wr));
endmodule

// File: tb/bank_map_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for bank_map_ctrl: one task per scenario.
module bank_map_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        rom_cs;
    logic [11:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic        ram_cs, ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic        attr_cs, attr_we;
    logic [11:0] attr_addr;
    logic [7:0]  attr_wdata, attr_rdata;
    logic        floppy_cs, busif_cs, serial_cs, video_cs;
    logic [1:0]  periph_reg;
    logic        periph_rd, periph_wr;
    logic [7:0]  periph_rdata;
    logic        overlay_on, attr_on, disp_hires, disp_shift;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // Behavioural stand-ins for the arrays and peripherals
    logic [7:0] attr_mem [16];
    assign rom_rdata    = rom_addr[7:0] + 8'h11;
    assign ram_rdata    = ram_addr[15:8] ^ ram_addr[7:0] ^ 8'h5A;
    assign attr_rdata   = attr_mem[attr_addr[3:0]];
    assign periph_rdata = 8'hC3;
    always @(posedge clk) if (attr_cs && attr_we) attr_mem[attr_addr[3:0]] <= attr_wdata;

    bank_map_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_wr(io_wr), .cpu_rdata(cpu_rdata),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .attr_cs(attr_cs), .attr_we(attr_we), .attr_addr(attr_addr),
        .attr_wdata(attr_wdata), .attr_rdata(attr_rdata),
        .floppy_cs(floppy_cs), .busif_cs(busif_cs), .serial_cs(serial_cs),
        .video_cs(video_cs), .periph_reg(periph_reg), .periph_rd(periph_rd),
        .periph_wr(periph_wr), .periph_rdata(periph_rdata),
        .overlay_on(overlay_on), .attr_on(attr_on),
        .disp_hires(disp_hires), .disp_shift(disp_shift)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a memory access at the falling edge and let decode settle
    task automatic bus(input logic [15:0] a, input logic [7:0] d,
                       input bit rd, input bit wr);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; mem_rd = rd; mem_wr = wr; io_wr = 1'b0;
        #1;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0; io_wr = 1'b0;
        #1;
    endtask

    // One-cycle I/O write; on return the edge that samples it has passed
    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; mem_rd = 1'b0; mem_wr = 1'b0; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        check(overlay_on == 1'b1 && attr_on == 1'b0, "R1 flags",
              {overlay_on, attr_on}, 2'b10);
        check(disp_hires == 1'b0 && disp_shift == 1'b0, "R1 display",
              {disp_hires, disp_shift}, 2'b00);
    endtask

    task automatic t_io_actions();
        // R2 overlay off via a port with high bits set; R12 timing
        @(negedge clk);
        cpu_addr = 16'h00FD; cpu_wdata = 8'h00; io_wr = 1'b1;
        #1;
        check(overlay_on == 1'b1, "R12 before edge", overlay_on, 1);
        @(negedge clk);
        io_wr = 1'b0;
        #1;
        check(overlay_on == 1'b0, "R2 off via 0xFD", overlay_on, 0);
        io_write(16'h0040, 8'hFF);
        check(overlay_on == 1'b1, "R2 on via 0x40 data FF", overlay_on, 1);
        io_write(16'h00B6, 8'h00);
        check(attr_on == 1'b1 && overlay_on == 1'b1, "R2 attr set via 0xB6",
              {attr_on, overlay_on}, 2'b11);
        io_write(16'h0007, 8'hAA);
        check(attr_on == 1'b0, "R2 attr clear via 0x07", attr_on, 0);
        // no action without io_wr
        bus(16'h0001, 8'h00, 1'b0, 1'b1);
        bus_idle();
        check(overlay_on == 1'b1, "R2 mem write is not I/O", overlay_on, 1);
    endtask

    task automatic t_overlay_rom();
        bus(16'h0234, 8'h00, 1'b1, 1'b0);
        check(rom_cs && rom_addr == 12'h234 && !ram_cs, "R3 rom low",
              {rom_cs, rom_addr}, {1'b1, 12'h234});
        check(cpu_rdata == 8'h45, "R3 rom data", cpu_rdata, 8'h45);
        bus(16'h1234, 8'h00, 1'b1, 1'b0);
        check(rom_cs && rom_addr == 12'h234 && cpu_rdata == 8'h45, "R3 rom mirror",
              cpu_rdata, 8'h45);
        bus(16'h0100, 8'h77, 1'b0, 1'b1);
        check(!rom_cs && !ram_cs && !ram_we, "R4 write dropped low",
              {rom_cs, ram_cs, ram_we}, 0);
        bus(16'h1F00, 8'h77, 1'b0, 1'b1);
        check(!rom_cs && !ram_cs && !ram_we && !periph_wr, "R4 write dropped mirror",
              {rom_cs, ram_cs, ram_we, periph_wr}, 0);
        bus_idle();
    endtask

    task automatic win_rd(input logic [15:0] a, input logic [3:0] exp_sel,
                          input logic [7:0] exp_d, input string tag);
        bus(a, 8'h00, 1'b1, 1'b0);
        // selects ordered {floppy, busif, serial, video}
        check({floppy_cs, busif_cs, serial_cs, video_cs} == exp_sel, {"R5 ", tag},
              {floppy_cs, busif_cs, serial_cs, video_cs}, exp_sel);
        check(cpu_rdata == exp_d && !ram_cs, {"R6 ", tag}, cpu_rdata, exp_d);
    endtask

    task automatic t_window();
        win_rd(16'h2100, 4'b1000, 8'hC3, "floppy 2100");
        win_rd(16'h2900, 4'b0100, 8'hC3, "busif 2900");
        win_rd(16'h2A00, 4'b0010, 8'hC3, "serial 2A00");
        win_rd(16'h2C00, 4'b0001, 8'hC3, "video 2C00");
        win_rd(16'h3F00, 4'b0111, 8'hC3, "overlap 3F00");
        win_rd(16'h3D01, 4'b0101, 8'hC3, "mirror 3D01");
        check(periph_reg == 2'd1 && periph_rd, "R5 reg index", periph_reg, 1);
        win_rd(16'h2000, 4'b0000, 8'hFF, "none 2000");
        win_rd(16'h2800, 4'b0000, 8'hFF, "none 2800");
        win_rd(16'h2400, 4'b0000, 8'hFF, "display-only 2400");
        bus_idle();
    endtask

    task automatic t_display();
        // R11: 0x2500 hits floppy and display together
        bus(16'h2500, 8'h01, 1'b0, 1'b1);
        check(floppy_cs && periph_wr && periph_reg == 2'd0, "R5 fdc+disp write",
              {floppy_cs, periph_wr}, 2'b11);
        bus_idle();
        check(disp_hires == 1'b1 && disp_shift == 1'b0, "R11 latch 01",
              {disp_hires, disp_shift}, 2'b10);
        bus(16'h3402, 8'h02, 1'b0, 1'b1);
        bus_idle();
        check(disp_hires == 1'b0 && disp_shift == 1'b1, "R11 latch 02 mirror",
              {disp_hires, disp_shift}, 2'b01);
        bus(16'h2100, 8'h03, 1'b0, 1'b1);
        bus_idle();
        check(disp_hires == 1'b0 && disp_shift == 1'b1, "R11 other reg no effect",
              {disp_hires, disp_shift}, 2'b01);
    endtask

    task automatic t_all_ram();
        io_write(16'h0001, 8'h00);
        bus(16'h0234, 8'h00, 1'b1, 1'b0);
        check(ram_cs && !rom_cs && ram_addr == 16'h0234 && cpu_rdata == 8'h6C,
              "R7 low read ram", cpu_rdata, 8'h6C);
        bus(16'h2C01, 8'h9E, 1'b0, 1'b1);
        check(ram_we && ram_addr == 16'h2C01 && ram_wdata == 8'h9E && !video_cs,
              "R7 window write ram", {ram_we, ram_addr}, {1'b1, 16'h2C01});
        bus(16'h1000, 8'h33, 1'b0, 1'b1);
        check(ram_we && ram_addr == 16'h1000, "R7 mirror write ram", ram_addr, 16'h1000);
        bus_idle();
        io_write(16'h0000, 8'h00);
        bus(16'h8123, 8'h00, 1'b1, 1'b0);
        check(ram_cs && cpu_rdata == 8'hF8, "R8 mid ram overlay on", cpu_rdata, 8'hF8);
        bus(16'h4000, 8'h55, 1'b0, 1'b1);
        check(ram_we && ram_addr == 16'h4000, "R8 mid write", ram_addr, 16'h4000);
        bus_idle();
    endtask

    task automatic t_attr();
        bus(16'hF003, 8'h12, 1'b0, 1'b1);
        check(ram_we && !attr_cs && ram_wdata == 8'h12, "R10 top page ram",
              {ram_we, attr_cs}, 2'b10);
        bus_idle();
        io_write(16'h0002, 8'h00);
        bus(16'hF003, 8'h00, 1'b0, 1'b1);
        check(attr_we && !ram_cs && attr_addr == 12'h003 && attr_wdata == 8'h7F,
              "R9 attr write 00", attr_wdata, 8'h7F);
        bus(16'hF003, 8'h00, 1'b1, 1'b0);
        check(cpu_rdata == 8'h7F, "R9 attr readback", cpu_rdata, 8'h7F);
        bus(16'hFFF5, 8'h80, 1'b0, 1'b1);
        bus(16'hFFF5, 8'h00, 1'b1, 1'b0);
        check(attr_cs && attr_addr == 12'hFF5 && cpu_rdata == 8'hFF,
              "R9 attr write 80", cpu_rdata, 8'hFF);
        bus(16'hEFFF, 8'h00, 1'b1, 1'b0);
        check(ram_cs && !attr_cs, "R8 below top page", {ram_cs, attr_cs}, 2'b10);
        bus_idle();
        io_write(16'h0003, 8'h00);
        bus(16'hF003, 8'h00, 1'b1, 1'b0);
        check(ram_cs && !attr_cs && cpu_rdata == 8'hA9, "R10 after clear", cpu_rdata, 8'hA9);
        bus_idle();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) attr_mem[i] = 8'h00;
        t_reset();
        t_io_actions();
        t_overlay_rom();
        t_window();
        t_display();
        t_all_ram();
        t_attr();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule